// File: doc/BRIEF.md
# Subarray Precharge Gating Controller

This block decides, interval by interval, which SRAM subarrays of a data array keep their bitlines precharged. Each access names a subarray through a few index bits and is qualified by a valid strobe. The controller counts accesses per subarray over a programmable number of cycles. At the end of each interval it withholds precharge from the subarrays that stayed below a usage threshold. This saves bitline power in parts of the array that are rarely touched.

An access that lands on a subarray whose precharge is off cannot complete in the normal time. For such an access the controller raises a one-cycle extra-latency flag, which the load pipeline uses to absorb the longer hit. The same access turns precharge back on for that subarray until the next interval boundary. After reset every subarray is precharged.

Top module: `pchg_gate_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `pre_en` is all ones and `slow_acc` is 0.
- R2: Each subarray's usage count saturates at 63 (6 bits). A subarray accessed 64 or more times in one interval still meets a threshold of 63.
- R3: An interval lasts `interval_len` cycles. A value of 0 is treated as 1, so that every cycle closes an interval. The cycle counter starts at 0 when reset is released.
- R4: At the clock edge that closes an interval, bit i of `pre_en` becomes 1 when subarray i's count, including an access made in that closing cycle, is at or above `threshold`. Otherwise the bit becomes 0.
- R5: All usage counts restart from 0 after each interval boundary.
- R6: When `acc_valid` is high and bit `acc_sub` of `pre_en` is 0, `slow_acc` is 1 in the next cycle. The flag lasts that one cycle unless the next access also hits a gated subarray.
- R7: An access to a gated subarray sets its `pre_en` bit at the next edge. The bit stays set until the next interval boundary.
- R8: An access to a subarray that is already precharged leaves `slow_acc` at 0. While `acc_valid` is low, `acc_sub` has no effect on any output.
- R9: A subarray accessed in the closing cycle of an interval is precharged in the new interval, whatever its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is made this cycle |
| acc_sub | input | 3 | Subarray number of the access (index bits) |
| interval_len | input | 16 | Interval length in cycles (0 acts as 1) |
| threshold | input | 6 | Minimum count for precharge to stay on next interval |
| pre_en | output | 8 | Precharge enable, one bit per subarray |
| slow_acc | output | 1 | Extra-latency flag for the access made in the previous cycle |

## Verification
The bench tests the count at the point where it would wrap. A counter that wraps instead of saturating reads 0 after 64 accesses and drops a heavily used subarray. It also tests accesses in the closing cycle. A design that left them out of the count, or did not force the accessed subarray on, would gate a subarray that was just used. An interval length of 0 and an exact four-cycle interval check the boundary timing: an off-by-one counter moves the moment `pre_en` falls by a cycle. Accesses to subarrays that are already on, and idle cycles where `acc_sub` changes, confirm that a loose decode neither raises the latency flag nor changes the enables.

// File: rtl/pchg_gate_ctrl.sv
module pchg_gate_ctrl #(
  parameter int NUM_SUB = 8,
  parameter int CNT_W   = 6,
  parameter int IVL_W   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       acc_valid,
  input  logic [$clog2(NUM_SUB)-1:0] acc_sub,
  input  logic [IVL_W-1:0]           interval_len,
  input  logic [CNT_W-1:0]           threshold,
  output logic [NUM_SUB-1:0]         pre_en,
  output logic                       slow_acc
);
  localparam int SEL_W = $clog2(NUM_SUB);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [IVL_W-1:0] ivl_cnt;
  logic [IVL_W-1:0] ivl_last;
  logic             boundary;
  logic [CNT_W-1:0] use_cnt [NUM_SUB];
  logic [CNT_W-1:0] use_eff [NUM_SUB];
  logic [NUM_SUB-1:0] hit;

  assign ivl_last = (interval_len == '0) ? '0 : interval_len - 1'b1;
  assign boundary = (ivl_cnt >= ivl_last);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        ivl_cnt <= '0;
    else if (boundary) ivl_cnt <= '0;
    else               ivl_cnt <= ivl_cnt + 1'b1;

  for (genvar g = 0; g < NUM_SUB; g++) begin : g_sub
    assign hit[g]     = acc_valid && (acc_sub == SEL_W'(g));
    assign use_eff[g] = (hit[g] && use_cnt[g] != CNT_MAX) ? use_cnt[g] + 1'b1 : use_cnt[g];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)        use_cnt[g] <= '0;
      else if (boundary) use_cnt[g] <= '0;
      else               use_cnt[g] <= use_eff[g];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre_en <= '1;
    end else begin
      for (int i = 0; i < NUM_SUB; i++)
        if (boundary)    pre_en[i] <= (use_eff[i] >= threshold) || hit[i];
        else if (hit[i]) pre_en[i] <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) slow_acc <= 1'b0;
    else        slow_acc <= acc_valid && !pre_en[acc_sub];

  // R1
  reset_state_chk: assert property (@(posedge clk) !rst_n |=> (&pre_en && !slow_acc));

  // R3
  ivl_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> ivl_cnt == $past(ivl_cnt) + 1'b1);

  // R5
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> use_cnt[0] == '0 || use_cnt[0] == CNT_W'(1));

  // R6
  slow_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slow_acc |-> $past(acc_valid));

  // R7
  reenable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> pre_en[$past(acc_sub)]);

  // R8
  warm_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && pre_en[acc_sub]) |=> !slow_acc);

  // R4
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid || boundary) |=> $stable(pre_en));
endmodule

// File: tb/pchg_gate_ctrl_tb.sv
module pchg_gate_ctrl_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       acc_v = 0;
  logic [2:0] acc_s = 0;
  logic [15:0] ilen = 16'd8;
  logic [5:0] thr = 6'd2;
  logic [7:0] pre_en;
  logic       slow_acc;

  int vectors = 0;
  int miss = 0;

  pchg_gate_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_v), .acc_sub(acc_s),
    .interval_len(ilen), .threshold(thr), .pre_en(pre_en), .slow_acc(slow_acc)
  );

  always #5 clk = ~clk;

  int       m_cnt [8];
  bit [7:0] m_pre = 8'hFF;
  bit       m_slow = 0;
  int       m_ivl = 0;

  always @(posedge clk) begin : model
    int lim;
    bit bnd;
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) m_cnt[i] = 0;
      m_pre = 8'hFF; m_slow = 0; m_ivl = 0;
    end else begin
      lim = (ilen == 0) ? 0 : int'(ilen) - 1;
      bnd = (m_ivl >= lim);
      m_slow = acc_v && !m_pre[acc_s];
      if (acc_v && m_cnt[acc_s] < 63) m_cnt[acc_s]++;
      if (bnd) begin
        for (int i = 0; i < 8; i++) begin
          m_pre[i] = (m_cnt[i] >= int'(thr)) || (acc_v && int'(acc_s) == i);
          m_cnt[i] = 0;
        end
        m_ivl = 0;
      end else begin
        if (acc_v) m_pre[acc_s] = 1'b1;
        m_ivl++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miss++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    chk(pre_en == m_pre, "R4 R5 R7 R9 model pre_en", pre_en, m_pre);
    chk(slow_acc == m_slow, "R6 R8 model slow_acc", slow_acc, m_slow);
  endtask

  task automatic hit(input int s);
    acc_v = 1; acc_s = 3'(s);
    step();
    acc_v = 0;
  endtask

  task automatic close_now();
    ilen = 16'd1;
    step();
    ilen = 16'd1000;
  endtask

  initial begin : watchdog
    #2_000_000;
    miss++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(); step();
    // R1
    chk(pre_en == 8'hFF, "R1 reset pre_en", pre_en, 8'hFF);
    chk(slow_acc == 0, "R1 reset slow_acc", slow_acc, 0);
    rst_n = 1;
    step();
    chk(pre_en == 8'hFF, "R1 first cycle pre_en", pre_en, 8'hFF);

    // idle first interval: all fall below threshold 2 (R4)
    for (int k = 0; k < 9; k++) step();
    chk(pre_en == 8'h00, "R4 idle interval gates all", pre_en, 0);
    ilen = 16'd1000;

    // R6 R7: cold access
    hit(2);
    chk(slow_acc == 1, "R6 flag after cold access", slow_acc, 1);
    chk(pre_en == 8'h04, "R7 re-enabled", pre_en, 8'h04);
    step();
    chk(slow_acc == 0, "R6 flag lasts one cycle", slow_acc, 0);
    // R8: warm access, and ignored select
    hit(2);
    chk(slow_acc == 0, "R8 warm access no flag", slow_acc, 0);
    for (int k = 0; k < 8; k++) begin
      acc_s = 3'(k);
      step();
    end
    chk(pre_en == 8'h04, "R8 idle select ignored", pre_en, 8'h04);
    chk(slow_acc == 0, "R8 idle select no flag", slow_acc, 0);

    hit(5);
    for (int k = 0; k < 5; k++) hit(7);
    chk(pre_en == 8'hA4, "R7 stays on within interval", pre_en, 8'hA4);
    close_now();
    chk(pre_en == 8'h84, "R4 threshold decision", pre_en, 8'h84);
    close_now();
    chk(pre_en == 8'h00, "R5 counts cleared", pre_en, 0);

    // R9: access in the closing cycle
    acc_v = 1; acc_s = 3'd4; ilen = 16'd1;
    step();
    acc_v = 0; ilen = 16'd1000;
    chk(pre_en == 8'h10, "R9 closing access kept on", pre_en, 8'h10);
    chk(slow_acc == 1, "R6 closing access flagged", slow_acc, 1);

    // R2: saturation
    thr = 6'd63;
    for (int k = 0; k < 70; k++) hit(1);
    for (int k = 0; k < 62; k++) hit(3);
    close_now();
    chk(pre_en == 8'h02, "R2 saturating count", pre_en, 8'h02);

    // R3: zero length acts as one cycle
    thr = 6'd1;
    ilen = 16'd0;
    acc_v = 1; acc_s = 3'd6;
    step();
    acc_v = 0;
    chk(pre_en == 8'h40, "R3 len0 boundary with access", pre_en, 8'h40);
    step();
    chk(pre_en == 8'h00, "R3 len0 next cycle closes", pre_en, 0);

    // R3: exact four-cycle interval
    ilen = 16'd1000;
    hit(0);
    close_now();
    chk(pre_en == 8'h01, "R3 sync boundary", pre_en, 8'h01);
    ilen = 16'd4;
    step(); step(); step();
    chk(pre_en == 8'h01, "R3 before fourth edge", pre_en, 8'h01);
    step();
    chk(pre_en == 8'h00, "R3 at fourth edge", pre_en, 0);

    // R4 threshold zero enables all
    thr = 6'd0;
    for (int k = 0; k < 4; k++) step();
    chk(pre_en == 8'hFF, "R4 zero threshold", pre_en, 8'hFF);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end
endmodule